// File: doc/BRIEF.md
# Pulse-Aligned Three-Entry Elastic Store

This block moves 16-bit words from a write clock domain into a read clock domain through a small circular store. The read side steps its pointer once per read clock. Each time the pointer stands on entry 0 it raises an alignment pulse for one cycle. The pulse is launched from the falling edge of the read clock. Surrounding logic returns that pulse, with or without a register stage, on the alignment input of the write side. The write side samples the returned pulse on its rising edge together with the data. It uses the pulse to place its pointer a fixed distance behind the reader, so that a write never lands on the entry being read.

The write side also watches the spacing of the returned pulses. Spacing is counted in write cycles and should equal the store depth. A pulse that fails to appear when due, or one that arrives early, raises a fault flag. The flag drops again after two pulses in a row arrive at the correct spacing. The cadence monitor is a four-state machine. HUNT is the state out of reset, before any pulse has been seen. TRACK means the cadence is good. FAULT means the cadence has been lost. RECOVER means one correctly spaced pulse has been seen since the fault. Its transitions are:
- HUNT→TRACK on the first pulse.
- TRACK→FAULT on a missing or misspaced pulse.
- FAULT→RECOVER on a correctly spaced pulse.
- RECOVER→TRACK on a second correctly spaced pulse.
- RECOVER→FAULT on a missing or misspaced pulse.

Top module: `es_align_fifo`

## Requirements
- R1: `pulse_out` changes only on falling edges of `rclk`, so it is steady across every rising edge.
- R2: `pulse_out` is high for one `rclk` cycle in every three. It is first high in the half cycle that ends at the first rising edge after reset release.
- R3: `align_in` is sampled on rising edges of `wclk`. Until the first high sample, no word is stored and `fault` stays low.
- R4: A sampled pulse makes the word at the next `wclk` edge go to entry 0, and the words after it go to entries 1, 2, 0 and so on. With the pulse looped back directly, each word appears on `rd_data` after the second `rclk` rising edge that follows the edge that wrote it (same clock on both sides).
- R5: `rd_data` stays 0 after reset until the write side has started tracking and that state has crossed a two-stage synchronizer into the read domain.
- R6: With the pulse looped back through one `wclk` register stage, words still arrive complete and in order, one read cycle after they are written.
- R7: If no pulse is sampled exactly three write cycles after the previous one, `fault` rises one `wclk` edge after the edge where the pulse was due.
- R8: A pulse sampled at a spacing other than three write cycles raises `fault` and still realigns the write pointer to entry 0.
- R9: `fault` clears only after two consecutive pulses spaced three write cycles apart; a single correct pulse leaves it set.
- R10: While `rst_n` is low, `rd_data`, `pulse_out` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side word clock |
| rclk | input | 1 | Read-side word clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_data | input | 16 | Word sampled on the rising edge of `wclk` |
| align_in | input | 1 | Returned alignment pulse, sampled with `wr_data` |
| rd_data | output | 16 | Word leaving the store, registered on `rclk` |
| pulse_out | output | 1 | Alignment pulse, launched on the falling edge of `rclk` |
| fault | output | 1 | High while the returned pulse cadence is lost |

## Verification
The assertions assume that `align_in` is driven with the timing of `wr_data`: it is set away from the rising edge of `wclk` and held across it. They also assume that the loop delay is a whole number of write cycles, so that the pulse and the words stay together. The bench ties both clock ports to one clock. It changes every input three time units after a rising edge. It builds `align_in` from its own model of where the read pointer stands, with a loop delay of either zero or one cycle. Faults come only from a pulse the bench deliberately drops or inserts.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [1:0] {
        CAD_HUNT    = 2'd0,
        CAD_TRACK   = 2'd1,
        CAD_FAULT   = 2'd2,
        CAD_RECOVER = 2'd3
    } cad_state_e;

endpackage

// File: rtl/es_store.sv
module es_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 3,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTRW-1:0]  waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTRW-1:0]  raddr,
    output logic [WIDTH-1:0] rword
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge wclk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (we && (waddr == PTRW'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rword = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == PTRW'(i)) begin
                rword = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/es_cadence_mon.sv
module es_cadence_mon
    import es_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic wclk,
    input  logic rst_n,
    input  logic pulse_seen,
    output logic tracking,
    output logic fault
);

    localparam int GAPW = $clog2(DEPTH + 2);
    localparam logic [GAPW-1:0] GAP_DUE = GAPW'(DEPTH);
    localparam logic [GAPW-1:0] GAP_MAX = GAPW'(DEPTH + 1);

    cad_state_e       state_q, state_d;
    logic [GAPW-1:0]  gap_q;
    logic             on_time, overdue;

    assign on_time = pulse_seen && (gap_q == GAP_DUE);
    assign overdue = !pulse_seen && (gap_q >= GAP_DUE);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (pulse_seen) begin
            gap_q <= GAPW'(1);
        end else if (gap_q < GAP_MAX) begin
            gap_q <= gap_q + GAPW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAD_HUNT: begin
                if (pulse_seen) state_d = CAD_TRACK;
            end
            CAD_TRACK: begin
                if ((pulse_seen && !on_time) || overdue) state_d = CAD_FAULT;
            end
            CAD_FAULT: begin
                if (on_time) state_d = CAD_RECOVER;
            end
            CAD_RECOVER: begin
                if (on_time) state_d = CAD_TRACK;
                else if (pulse_seen || overdue) state_d = CAD_FAULT;
            end
            default: state_d = CAD_HUNT;
        endcase
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) state_q <= CAD_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        tracking = (state_q != CAD_HUNT);
        fault    = (state_q == CAD_FAULT) || (state_q == CAD_RECOVER);
    end

endmodule

// File: rtl/es_wr_side.sv
module es_wr_side #(
    parameter int WIDTH      = 16,
    parameter int DEPTH      = 3,
    parameter int ALIGN_SLOT = 0,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             align_in,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             tracking,
    output logic             pulse_seen,
    output logic             we,
    output logic [PTRW-1:0]  waddr,
    output logic [WIDTH-1:0] wdata
);

    localparam int ALIGN_NEXT = (ALIGN_SLOT == DEPTH - 1) ? 0 : ALIGN_SLOT + 1;

    logic            align_q;
    logic [PTRW-1:0] wptr_q;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) align_q <= 1'b0;
        else        align_q <= align_in;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (align_q) begin
            wptr_q <= PTRW'(ALIGN_NEXT);
        end else if (tracking) begin
            wptr_q <= (wptr_q == PTRW'(DEPTH - 1)) ? '0 : wptr_q + PTRW'(1);
        end
    end

    always_comb begin
        pulse_seen = align_q;
        we         = align_q || tracking;
        waddr      = align_q ? PTRW'(ALIGN_SLOT) : wptr_q;
        wdata      = wr_data;
    end

endmodule

// File: rtl/es_rd_side.sv
module es_rd_side #(
    parameter int WIDTH       = 16,
    parameter int DEPTH       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             tracking,
    input  logic [WIDTH-1:0] rword,
    output logic [PTRW-1:0]  raddr,
    output logic [WIDTH-1:0] rd_data,
    output logic             pulse_out
);

    logic [PTRW-1:0]        rptr_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic [WIDTH-1:0]       rd_q;
    logic                   pulse_q;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rptr_q <= '0;
        else        rptr_q <= (rptr_q == PTRW'(DEPTH - 1)) ? '0 : rptr_q + PTRW'(1);
    end

    always_ff @(negedge rclk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (rptr_q == '0);
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge rclk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= tracking;
            end
        end else begin : g_next
            always_ff @(posedge rclk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)                      rd_q <= '0;
        else if (sync_q[SYNC_STAGES-1])  rd_q <= rword;
        else                             rd_q <= '0;
    end

    always_comb begin
        raddr     = rptr_q;
        rd_data   = rd_q;
        pulse_out = pulse_q;
    end

endmodule

// File: rtl/es_align_fifo.sv
module es_align_fifo #(
    parameter int WIDTH       = 16,
    parameter int DEPTH       = 3,
    parameter int ALIGN_SLOT  = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             align_in,
    output logic [WIDTH-1:0] rd_data,
    output logic             pulse_out,
    output logic             fault
);

    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             tracking;
    logic             pulse_seen;
    logic             we;
    logic [PTRW-1:0]  waddr;
    logic [PTRW-1:0]  raddr;
    logic [WIDTH-1:0] wdata;
    logic [WIDTH-1:0] rword;

    es_wr_side #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .ALIGN_SLOT(ALIGN_SLOT)
    ) u_wr (
        .wclk(wclk), .rst_n(rst_n), .align_in(align_in), .wr_data(wr_data),
        .tracking(tracking), .pulse_seen(pulse_seen), .we(we),
        .waddr(waddr), .wdata(wdata)
    );

    es_cadence_mon #(.DEPTH(DEPTH)) u_mon (
        .wclk(wclk), .rst_n(rst_n), .pulse_seen(pulse_seen),
        .tracking(tracking), .fault(fault)
    );

    es_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .wclk(wclk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rword(rword)
    );

    es_rd_side #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)
    ) u_rd (
        .rclk(rclk), .rst_n(rst_n), .tracking(tracking), .rword(rword),
        .raddr(raddr), .rd_data(rd_data), .pulse_out(pulse_out)
    );

endmodule

// File: rtl/es_align_fifo_chk.sv
module es_align_fifo_chk #(
    parameter int WIDTH = 16
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             align_in,
    input logic [WIDTH-1:0] rd_data,
    input logic             pulse_out,
    input logic             fault
);

    logic seen_q;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n)        seen_q <= 1'b0;
        else if (align_in) seen_q <= 1'b1;
    end

    // R2
    pulse_cadence_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        pulse_out |=> !pulse_out ##1 !pulse_out ##1 pulse_out);

    // R5
    zero_before_align_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !seen_q |-> (rd_data == '0));

    // R3
    no_fault_in_hunt_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !seen_q |-> !fault);

    // R9
    fault_clear_cause_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(fault) |-> $past(align_in, 2));

endmodule

bind es_align_fifo es_align_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .align_in(align_in),
    .rd_data(rd_data), .pulse_out(pulse_out), .fault(fault)
);

// File: tb/es_align_fifo_test.sv
module es_align_fifo_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic        align_in = 1'b0;
    logic [15:0] rd_data;
    logic        pulse_out;
    logic        fault;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural reference state
    int          m_rdptr, m_wptr, m_st, m_gap, ecount, lat;
    bit          m_s1, m_s2, m_aq;
    logic [15:0] m_rd;
    logic [15:0] m_mem [3];
    logic [15:0] hist [1024];
    string       dtag, ftag;

    always #(CLK_PERIOD/2) clk = ~clk;

    es_align_fifo uut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .align_in(align_in), .rd_data(rd_data), .pulse_out(pulse_out),
        .fault(fault)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (edge %0d)", tag, what, act, exp, ecount);
        end
    endtask

    task automatic model_reset();
        m_rdptr = 0; m_wptr = 0; m_st = 0; m_gap = 0; ecount = 0; lat = 0;
        m_s1 = 0; m_s2 = 0; m_aq = 0; m_rd = '0;
        for (int i = 0; i < 3; i++) m_mem[i] = '0;
    endtask

    task automatic model_edge(input bit al, input logic [15:0] d);
        bit trk;
        int st_n;
        trk = (m_st != 0);
        m_rd = m_s2 ? m_mem[m_rdptr] : 16'h0;
        m_s2 = m_s1;
        m_s1 = trk;
        m_rdptr = (m_rdptr + 1) % 3;
        if (m_aq) begin
            m_mem[0] = d; m_wptr = 1;
        end else if (trk) begin
            m_mem[m_wptr] = d; m_wptr = (m_wptr + 1) % 3;
        end
        st_n = m_st;
        case (m_st)
            0: if (m_aq) st_n = 1;
            1: if ((m_aq && m_gap != 3) || (!m_aq && m_gap >= 3)) st_n = 2;
            2: if (m_aq && m_gap == 3) st_n = 3;
            default: begin
                if (m_aq) st_n = (m_gap == 3) ? 1 : 2;
                else if (m_gap >= 3) st_n = 2;
            end
        endcase
        if (m_aq) m_gap = 1;
        else if (m_gap < 4) m_gap++;
        m_st = st_n;
        m_aq = al;
        ecount++;
        hist[ecount] = d;
    endtask

    // called at rising edge + 3
    task automatic cycle(input bit al, input logic [15:0] d);
        logic p_before;
        align_in = al;
        wr_data  = d;
        #(CLK_PERIOD/2);
        check("R2", {15'b0, pulse_out}, {15'b0, (m_rdptr == 0)}, "pulse_out");
        check(dtag, rd_data, m_rd, "rd_data");
        check(ftag, {15'b0, fault}, {15'b0, (m_st >= 2)}, "fault");
        if (lat > 0) check(lat == 2 ? "R4" : "R6", rd_data, hist[ecount - lat], "latency word");
        p_before = pulse_out;
        @(posedge clk);
        model_edge(al, d);
        #3;
        check("R1", {15'b0, pulse_out}, {15'b0, p_before}, "pulse across rising edge");
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'(k * 16'h1357 + 16'h00a5);
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R10", rd_data, 16'h0, "rd_data in reset");
        check("R10", {15'b0, pulse_out}, 16'h0, "pulse in reset");
        check("R10", {15'b0, fault}, 16'h0, "fault in reset");
        rst_n = 1'b1;
        #2;

        // hunting: no pulse returned yet
        dtag = "R5"; ftag = "R3";
        for (int k = 0; k < 6; k++) cycle(1'b0, pat(k));

        // direct loop-back
        dtag = "R5"; ftag = "R3";
        for (int k = 0; k < 30; k++) begin
            if (k == 8) dtag = "R4";
            if (k == 10) lat = 2;
            cycle(m_rdptr == 0, pat(100 + k));
        end

        // one due pulse dropped, then normal cadence
        lat = 0; dtag = "R7"; ftag = "R7";
        while (m_rdptr != 0) cycle(1'b0 | (m_rdptr == 0), pat(200 + ecount));
        cycle(1'b0, pat(300));
        for (int k = 0; k < 4; k++) cycle(m_rdptr == 0, pat(310 + k));
        ftag = "R9";
        for (int k = 0; k < 14; k++) cycle(m_rdptr == 0, pat(320 + k));

        // an early extra pulse
        dtag = "R8"; ftag = "R8";
        while (m_rdptr != 1) cycle(m_rdptr == 0, pat(400 + ecount));
        cycle(1'b1, pat(410));
        for (int k = 0; k < 4; k++) cycle(m_rdptr == 0, pat(420 + k));
        ftag = "R9";
        for (int k = 0; k < 14; k++) cycle(m_rdptr == 0, pat(430 + k));

        // loop with one register stage
        dtag = "R6"; ftag = "R6";
        for (int k = 0; k < 30; k++) begin
            if (k == 15) lat = 1;
            cycle(m_rdptr == 1, pat(500 + k));
        end
        lat = 0;
        check("R9", {15'b0, fault}, 16'h0, "fault after settled delayed loop");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule